// File: doc/BRIEF.md
# Kernel Launch Register Window

This block is the host-facing register window through which a kernel dispatch is prepared and started. The host fills a descriptor buffer one field at a time through byte-addressed writes placed above an 8-byte launch/status word at the bottom of the window. A write of any legal size to offset zero snapshots the whole descriptor, tags it with the next kernel number and places it in a small launch queue. The downstream work scheduler takes queued launches with a valid/ready handshake.

Each request is a single-cycle strobe carrying direction, address, byte count and write data. Every request, good or bad, gets exactly one response a fixed number of cycles later, carrying an error bit and read data. Reading the status word reports whether launches are still waiting in the queue. Reading above it returns descriptor bytes, least significant byte first.

Top module: `kernel_launch_regs`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rsp_valid` and `launch_valid` are low. After reset the status word reads 0, every descriptor byte reads 0 and the next kernel number is 0.
- R2: Every request sampled with `req_valid` high produces exactly one response, with `rsp_valid` high exactly RESP_LAT cycles later. Requests may arrive on back-to-back cycles.
- R3: A read at offset 0 with a byte count of 8 returns bit 0 = 1 while the launch queue holds at least one entry, and bit 0 = 0 otherwise. Bits 63..1 are zero.
- R4: An access at offset A ≥ 8 with byte count N targets descriptor bytes A−8 up to A−8+N−1. Write byte k comes from `req_wdata[8k+7:8k]`. Read byte k is returned in `rsp_rdata[8k+7:8k]`, and the read data bits above the N bytes are zero.
- R5: A byte count other than 1, 2, 4 or 8 gets an error response and has no effect on the descriptor, the queue or the kernel number.
- R6: A descriptor access whose last byte (A−8+N−1) lies at or beyond DESC_BYTES gets an error response. Such a write changes nothing, and such a read returns zero data.
- R7: An access at offsets 1 to 7, or a read at offset 0 whose byte count is not 8, gets an error response and has no effect.
- R8: A write of legal size at offset 0 starts a launch, whatever the data. The launch takes kernel number 0 after reset, and each later launch takes the previous number plus one, wrapping at 2^ID_W.
- R9: A queued launch carries the descriptor as it stood when its launch write was accepted; later descriptor writes do not change it. Launches leave in launch order. `launch_valid`, `launch_id` and `launch_desc` hold steady until `sched_ready` is high.
- R10: A launch write that arrives while the queue holds QDEPTH entries gets an error response, is not queued and uses no kernel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_size | input | 4 | Byte count of the access |
| req_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| sched_ready | input | 1 | Scheduler accepts the head launch |
| launch_valid | output | 1 | A launch is waiting |
| launch_id | output | ID_W | Kernel number of the head launch |
| launch_desc | output | DESC_BYTES*8 | Descriptor snapshot of the head launch |

## Verification
The assertions rely on only two things about the inputs. `req_valid` may be high on any cycle, so response bookkeeping is a running count rather than a fixed-depth history. `sched_ready` may change freely, with no promise of when it rises. The stimulus keeps every input stable between falling edges. It drives full, empty and draining queue states with `sched_ready` held low, held high and toggled at random, and it mixes back-to-back and spaced requests. Random accesses stay inside a narrow address band near the descriptor so that in-range, straddling and out-of-range cases all occur often.

// File: rtl/klr_pkg.sv
// Shared definitions for the kernel launch register window.
// Assumes byte counts arrive as plain binary values on a 4-bit field.
package klr_pkg;

    localparam int STATUS_BYTES = 8;
    localparam int BUS_BYTES    = 8;

    typedef enum logic [1:0] {
        ACC_BAD    = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_DESC   = 2'd2
    } acc_kind_e;

    // Legal transfer byte counts
    function automatic logic size_legal(input logic [3:0] n);
        return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd8);
    endfunction

endpackage

// File: rtl/klr_decode.sv
// Classifies an access as status, descriptor or illegal, and gives the
// descriptor byte index. Purely combinational; assumes DESC_BYTES + 8
// fits in the window.
module klr_decode
    import klr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DESC_BYTES = 32
) (
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    output acc_kind_e         kind,
    output logic [ADDR_W-1:0] base
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DESC_BYTES);

    // Decide access class from offset, direction and byte count
    always_comb begin
        base = req_addr - ADDR_W'(STATUS_BYTES);
        kind = ACC_BAD;
        if (size_legal(req_size)) begin
            if (req_addr < ADDR_W'(STATUS_BYTES)) begin
                if (req_addr == '0 && (req_write || req_size == 4'd8)) begin
                    kind = ACC_STATUS;
                end
            end else if (({1'b0, base} + (ADDR_W+1)'(req_size)) <= LIMIT) begin
                kind = ACC_DESC;
            end
        end
    end

endmodule

// File: rtl/klr_desc_store.sv
// Byte-addressed descriptor buffer. Writes up to 8 bytes starting at
// base; reads return up to 8 bytes starting at base, zero-filled.
// Assumes the caller only enables writes for in-range accesses.
module klr_desc_store #(
    parameter int DESC_BYTES = 32,
    parameter int IDX_W      = 12,
    localparam int DW        = DESC_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] base,
    input  logic [3:0]       size,
    input  logic [63:0]      wdata,
    output logic [63:0]      rd_data,
    output logic [DW-1:0]    store
);

    for (genvar i = 0; i < DESC_BYTES; i++) begin : g_byte
        logic [7:0]     byte_q;
        logic [IDX_W:0] rel;
        logic           hit;

        assign rel = (IDX_W+1)'(i) - {1'b0, base};
        assign hit = wr_en && ({1'b0, base} <= (IDX_W+1)'(i))
                     && (rel < (IDX_W+1)'(size));

        // Update this byte when the write window covers it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (hit) begin
                byte_q <= wdata[rel[2:0]*8 +: 8];
            end
        end

        assign store[i*8 +: 8] = byte_q;
    end

    // Gather up to eight bytes starting at base
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < 8; k++) begin
            if (4'(k) < size) begin
                if ((int'(base) + k) < DESC_BYTES) begin
                    rd_data[k*8 +: 8] = store[(int'(base) + k)*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/klr_launch_fifo.sv
// Launch queue holding {kernel number, descriptor} entries in order.
// Assumes the caller never pushes while full; a pop on empty is ignored.
module klr_launch_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 264,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         full
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             pop_ok;

    assign pop_ok    = pop && (count != '0);
    assign not_empty = (count != '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign dout      = mem[rd_ptr];

    // Store a new entry at the write pointer
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(push) - CNT_W'(pop_ok);
        end
    end

endmodule

// File: rtl/klr_resp_pipe.sv
// Fixed-latency response delay line. Assumes LAT >= 1.
module klr_resp_pipe #(
    parameter int LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_err,
    input  logic [63:0] in_data,
    output logic        out_valid,
    output logic        out_err,
    output logic [63:0] out_data
);

    logic [LAT-1:0] v_q;
    logic [LAT-1:0] e_q;
    logic [63:0]    d_q [LAT];

    // Shift each response one stage per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            e_q <= '0;
            for (int i = 0; i < LAT; i++) d_q[i] <= '0;
        end else begin
            v_q[0] <= in_valid;
            e_q[0] <= in_err;
            d_q[0] <= in_data;
            for (int i = 1; i < LAT; i++) begin
                v_q[i] <= v_q[i-1];
                e_q[i] <= e_q[i-1];
                d_q[i] <= d_q[i-1];
            end
        end
    end

    assign out_valid = v_q[LAT-1];
    assign out_err   = e_q[LAT-1];
    assign out_data  = d_q[LAT-1];

endmodule

// File: rtl/kernel_launch_regs.sv
// Host register window for building and launching kernel descriptors.
// Offset 0 is the launch/status word; offsets 8 and up map to descriptor
// bytes. Assumes one request per cycle at most and a scheduler that takes
// the head launch whenever sched_ready is high.
module kernel_launch_regs
    import klr_pkg::*;
#(
    parameter int WIN_BYTES  = 4096,
    parameter int DESC_BYTES = 32,
    parameter int ID_W       = 8,
    parameter int QDEPTH     = 4,
    parameter int RESP_LAT   = 2,
    localparam int ADDR_W    = $clog2(WIN_BYTES),
    localparam int DW        = DESC_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    input  logic              sched_ready,
    output logic              launch_valid,
    output logic [ID_W-1:0]   launch_id,
    output logic [DW-1:0]     launch_desc
);

    acc_kind_e         kind;
    logic [ADDR_W-1:0] base;
    logic [63:0]       desc_rd;
    logic [DW-1:0]     desc_now;
    logic [ID_W-1:0]   next_id_q;
    logic              q_full;
    logic              launch_try, push, desc_wr;
    logic              resp_err;
    logic [63:0]       resp_data;

    klr_decode #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_dec (
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .kind      (kind),
        .base      (base)
    );

    assign launch_try = req_valid && req_write && (kind == ACC_STATUS);
    assign push       = launch_try && !q_full;
    assign desc_wr    = req_valid && req_write && (kind == ACC_DESC);

    klr_desc_store #(.DESC_BYTES(DESC_BYTES), .IDX_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (desc_wr),
        .base    (base),
        .size    (req_size),
        .wdata   (req_wdata),
        .rd_data (desc_rd),
        .store   (desc_now)
    );

    // Kernel number counter, one step per accepted launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_id_q <= '0;
        end else if (push) begin
            next_id_q <= next_id_q + 1'b1;
        end
    end

    klr_launch_fifo #(.DEPTH(QDEPTH), .W(ID_W + DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .din       ({next_id_q, desc_now}),
        .pop       (sched_ready),
        .dout      ({launch_id, launch_desc}),
        .not_empty (launch_valid),
        .full      (q_full)
    );

    // Form the response for the access sampled this cycle
    always_comb begin
        resp_err  = (kind == ACC_BAD) || (launch_try && q_full);
        resp_data = '0;
        if (!req_write && kind == ACC_DESC) begin
            resp_data = desc_rd;
        end else if (!req_write && kind == ACC_STATUS) begin
            resp_data = {63'd0, launch_valid};
        end
    end

    klr_resp_pipe #(.LAT(RESP_LAT)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_err    (req_valid && resp_err),
        .in_data   (req_valid ? resp_data : 64'd0),
        .out_valid (rsp_valid),
        .out_err   (rsp_err),
        .out_data  (rsp_rdata)
    );

endmodule

// File: rtl/klr_checker.sv
// Temporal checks on the launch register window, bound to its top.
// Tracks outstanding requests and the last handed-off kernel number.
module klr_checker #(
    parameter int ID_W = 8,
    parameter int DW   = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic            sched_ready,
    input logic            launch_valid,
    input logic [ID_W-1:0] launch_id,
    input logic [DW-1:0]   launch_desc
);

    int unsigned     outstanding;
    logic            seen_pop;
    logic [ID_W-1:0] last_id;

    // Count requests awaiting a response and remember handed-off numbers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 0;
            seen_pop    <= 1'b0;
            last_id     <= '0;
        end else begin
            outstanding <= outstanding + (req_valid ? 1 : 0) - (rsp_valid ? 1 : 0);
            if (launch_valid && sched_ready) begin
                seen_pop <= 1'b1;
                last_id  <= launch_id;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!launch_valid && !rsp_valid));

    // R2
    rsp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (outstanding != 0));

    // R9
    launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && !sched_ready) |=>
        (launch_valid && $stable(launch_id) && $stable(launch_desc)));

    // R8
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && sched_ready && seen_pop) |-> (launch_id == ID_W'(last_id + 1'b1)));

endmodule

bind kernel_launch_regs klr_checker #(.ID_W(ID_W), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .rsp_valid    (rsp_valid),
    .sched_ready  (sched_ready),
    .launch_valid (launch_valid),
    .launch_id    (launch_id),
    .launch_desc  (launch_desc)
);

// File: tb/kernel_launch_regs_test.sv
// Behavioural reference model compared against the window on every cycle.
module kernel_launch_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 4096;
    localparam int DESCB = 32;
    localparam int IDW   = 8;
    localparam int QD    = 4;
    localparam int LAT   = 2;
    localparam int AW    = $clog2(WIN);
    localparam int DW    = DESCB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_size = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [63:0]   rsp_rdata;
    logic          sched_ready = 1'b0;
    logic          launch_valid;
    logic [IDW-1:0] launch_id;
    logic [DW-1:0] launch_desc;

    int total = 0;
    int bad   = 0;

    kernel_launch_regs #(.WIN_BYTES(WIN), .DESC_BYTES(DESCB), .ID_W(IDW),
                         .QDEPTH(QD), .RESP_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .sched_ready(sched_ready), .launch_valid(launch_valid),
        .launch_id(launch_id), .launch_desc(launch_desc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    typedef struct {
        int            id;
        logic [DW-1:0] d;
    } ent_t;

    logic [7:0]  m_desc [DESCB];
    ent_t        mq[$];
    int          m_next;
    logic        ev [LAT];
    logic        eerr [LAT];
    logic [63:0] edat [LAT];
    string       etag [LAT];

    function automatic logic [DW-1:0] snap();
        logic [DW-1:0] v;
        for (int i = 0; i < DESCB; i++) v[i*8 +: 8] = m_desc[i];
        return v;
    endfunction

    always @(posedge clk) begin : model
        logic        r_e;
        logic [63:0] r_d;
        string       r_t;
        bit          do_push;
        int          qn, a, s, b;
        ent_t        ne;
        if (!rst_n) begin
            for (int i = 0; i < DESCB; i++) m_desc[i] = 8'h00;
            mq.delete();
            m_next = 0;
            for (int i = 0; i < LAT; i++) begin
                ev[i] = 1'b0; eerr[i] = 1'b0; edat[i] = '0; etag[i] = "R1";
            end
        end else begin
            r_e = 1'b0; r_d = '0; r_t = "R2"; do_push = 1'b0;
            qn = mq.size();
            a = int'(req_addr); s = int'(req_size);
            if (req_valid) begin
                if (!(s == 1 || s == 2 || s == 4 || s == 8)) begin
                    r_e = 1'b1; r_t = "R5";
                end else if (a < 8) begin
                    if (a != 0) begin
                        r_e = 1'b1; r_t = "R7";
                    end else if (req_write) begin
                        if (qn == QD) begin
                            r_e = 1'b1; r_t = "R10";
                        end else begin
                            do_push = 1'b1; r_t = "R8";
                            ne.id = m_next; ne.d = snap();
                        end
                    end else if (s != 8) begin
                        r_e = 1'b1; r_t = "R7";
                    end else begin
                        r_d = (qn != 0) ? 64'd1 : 64'd0; r_t = "R3";
                    end
                end else begin
                    b = a - 8;
                    if (b + s > DESCB) begin
                        r_e = 1'b1; r_t = "R6";
                    end else begin
                        r_t = "R4";
                        for (int k = 0; k < s; k++) begin
                            if (req_write) m_desc[b+k] = req_wdata[k*8 +: 8];
                            else r_d[k*8 +: 8] = m_desc[b+k];
                        end
                    end
                end
            end
            for (int i = LAT-1; i > 0; i--) begin
                ev[i] = ev[i-1]; eerr[i] = eerr[i-1]; edat[i] = edat[i-1]; etag[i] = etag[i-1];
            end
            ev[0] = req_valid; eerr[0] = r_e; edat[0] = r_d; etag[0] = r_t;
            if (qn > 0 && sched_ready) void'(mq.pop_front());
            if (do_push) begin
                mq.push_back(ne);
                m_next = (m_next + 1) % (1 << IDW);
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare outputs against the model between clock edges
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rsp_valid == ev[LAT-1], "R2 rsp_valid", DW'(rsp_valid), DW'(ev[LAT-1]));
            if (ev[LAT-1]) begin
                chk(rsp_err == eerr[LAT-1], {etag[LAT-1], " err"}, DW'(rsp_err), DW'(eerr[LAT-1]));
                chk(rsp_rdata == edat[LAT-1], {etag[LAT-1], " data"}, DW'(rsp_rdata), DW'(edat[LAT-1]));
            end
            chk(launch_valid == (mq.size() > 0), "R9 launch_valid",
                DW'(launch_valid), DW'(mq.size() > 0));
            if (mq.size() > 0) begin
                chk(int'(launch_id) == mq[0].id, "R8 launch_id", DW'(launch_id), DW'(mq[0].id));
                chk(launch_desc == mq[0].d, "R9 launch_desc", launch_desc, mq[0].d);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic acc(bit w, int a, int s, logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a);
        req_size = 4'(s); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int sizes [6] = '{1, 2, 3, 4, 8, 5};
        repeat (3) @(negedge clk);
        // R1 outputs quiet during reset
        chk(!rsp_valid && !launch_valid, "R1 reset", DW'({rsp_valid, launch_valid}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !launch_valid, "R1 after reset", DW'({rsp_valid, launch_valid}), '0);
        acc(0, 0, 8, 0);              // R1/R3 status 0
        acc(0, 8, 8, 0);              // R1 descriptor zero
        // R4 descriptor writes of every size, then read back
        acc(1, 8, 8, 64'h8877665544332211);
        acc(1, 16, 4, 64'hFFFF_FFFF_DDCC_BBAA);
        acc(1, 20, 2, 64'h1234);
        acc(1, 22, 1, 64'h5A);
        acc(1, 32, 8, 64'h0123456789ABCDEF);
        acc(0, 8, 8, 0); acc(0, 16, 8, 0); acc(0, 11, 2, 0); acc(0, 32, 8, 0);
        // R5 illegal sizes
        acc(1, 8, 3, 64'hFFFF_FFFF); acc(0, 8, 0, 0); acc(1, 0, 6, 0); acc(0, 8, 8, 0);
        // R6 straddling and beyond
        acc(1, 36, 8, '1); acc(0, 39, 1, 0); acc(0, 40, 1, 0); acc(1, 4000, 4, '1);
        acc(0, 36, 8, 0); acc(0, 32, 8, 0);
        // R7 inside the status word
        acc(1, 3, 1, 0); acc(0, 0, 4, 0); acc(0, 4, 4, 0);
        // R8 / R10 launches with scheduler stalled
        sched_ready = 1'b0;
        acc(1, 0, 1, 64'h0);
        acc(0, 0, 8, 0);              // R3 busy
        acc(1, 8, 8, 64'hCAFE);       // R9 later write leaves snapshot
        acc(1, 0, 8, 64'hDEAD_BEEF);
        acc(1, 0, 2, 64'h7);
        acc(1, 0, 4, 64'h1);
        acc(1, 0, 8, 64'h2);          // R10 queue full
        idle(4);
        sched_ready = 1'b1;
        idle(6);
        acc(0, 0, 8, 0);              // R3 drained
        acc(1, 0, 8, 0);              // R8 id continues
        // back-to-back requests with toggling scheduler
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            req_valid = 1'b1; req_write = i[0]; req_addr = AW'((i % 3 == 0) ? 0 : 8 + i);
            req_size = 4'(((i % 4) == 3) ? 8 : 1); req_wdata = 64'(i * 37);
            sched_ready = i[1];
            @(negedge clk);
        end
        req_valid = 1'b0;
        // random mix
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            req_valid   = ($urandom_range(0, 3) != 0);
            req_write   = $urandom_range(0, 1) == 1;
            req_addr    = AW'(($urandom_range(0, 5) == 0) ? 0 : $urandom_range(0, 48));
            req_size    = 4'(sizes[$urandom_range(0, 5)]);
            req_wdata   = {$urandom, $urandom};
            sched_ready = ($urandom_range(0, 3) == 0);
        end
        @(negedge clk);
        req_valid = 1'b0; sched_ready = 1'b1;
        idle(12);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule